// File: doc/BRIEF.md
# Product-Term Macrocell Array with Expanders

This block is an array of macrocells built the way a registered programmable-logic device is built. Each product term is the AND of literals picked from a programmable crosspoint array. The true and complement forms of every input pin are available, and so are the true and complement forms of every shared-expander output. Each macrocell sums its own cluster of product terms and can invert the sum. The result then either passes straight to the output or goes through a flip-flop on the system clock.

Three product terms of a cluster can be steered to other uses: an asynchronous clear, an asynchronous preset and a capture enable for the flip-flop. The fifth term can be lent to the next macrocell up, where it joins that macrocell's sum. Shared expanders are single product terms, built from pin literals only, whose inverted value returns to the crosspoint array as an extra input. Any term of any macrocell can use it, so the logic path takes two passes through the array.

The configuration is written one word at a time through an address/data port. An active-low reset clears the whole configuration and all flip-flops. Reset is applied at once and released through a two-stage synchronizer.

Top module: `sop_macro_block`

## Requirements
- R1: The crosspoint mask of a product term is encoded as follows: bit 2s selects the true form of signal s and bit 2s+1 selects its complement. Signals 0..7 are the input pins and signals 8..9 are shared expanders 0..1. The term is the AND of the selected literals. A term whose mask is all zero is off and contributes 0.
- R2: With control bit 1 (bypass) set, a macrocell output equals, with no clock edge, the OR of its non-steered product terms plus any term lent to it.
- R3: Control bit 0 inverts the macrocell sum. The inversion is applied before both the bypass path and the register.
- R4: With bypass clear, the output is the flip-flop. The flip-flop takes the (possibly inverted) sum on a rising clock edge, and the output does not change before that edge.
- R5: With control bit 4 set, term 3 is the capture enable and leaves the sum. While term 3 is 0, the flip-flop holds its value across clock edges.
- R6: With control bit 2 set, term 1 leaves the sum and clears the flip-flop asynchronously, with no clock edge needed. Clear wins over preset.
- R7: With control bit 3 set, term 2 leaves the sum and presets the flip-flop asynchronously, unless clear is also active.
- R8: With control bit 5 set, term 4 leaves macrocell m's own sum and is ORed into the sum of macrocell m+1 only. It does not pass on to m+2. On the highest macrocell, the lent term reaches no other macrocell.
- R9: A shared expander output is the inverted AND of the pin literals selected in its mask. Mask bits that select expander literals are ignored in an expander's own mask.
- R10: Writes decode the address as follows: macrocell m term t at m*5+t (0..79), shared expander s at 80+s, and control of macrocell m at 82+m. A write takes effect at the rising clock edge. Addresses above 97 change nothing.
- R11: While reset is low, every flip-flop and every configuration word is held at zero, so all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Logic input pins |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address |
| cfg_data | input | 20 | Configuration word (crosspoint mask or control bits) |
| mc_out | output | 16 | Macrocell outputs, bit m from macrocell m |

## Verification
Bypass outputs and shared-expander paths are purely combinational. The bench changes the pins at a falling edge and samples one time unit later, before any rising edge. Registered results are due at the first rising edge after the stimulus, so they are read at the falling edge that follows it; the enable-hold and capture checks also look at the sample taken just before that edge. Asynchronous clear and preset are sampled shortly after their inputs change and before the next rising edge, which shows that no clock is involved. Configuration writes and reset release are checked only after the edges that make them take effect: one edge for a write, two for the reset synchronizer.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Control word of one macrocell; inv sits in bit 0.
  typedef struct packed {
    logic lend;       // bit 5: lend term 4 to next macrocell
    logic steer_ena;  // bit 4: term 3 drives capture enable
    logic steer_pre;  // bit 3: term 2 drives async preset
    logic steer_clr;  // bit 2: term 1 drives async clear
    logic bypass;     // bit 1: combinational output
    logic inv;        // bit 0: invert the sum
  } mc_ctrl_t;

  localparam int CTRL_W = $bits(mc_ctrl_t);

  // Term index used by each steering option.
  localparam int T_CLR  = 1;
  localparam int T_PRE  = 2;
  localparam int T_ENA  = 3;
  localparam int T_LEND = 4;

endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_nxt;

  always_comb begin
    stage_nxt = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_nxt;
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/sop_cfg_regs.sv
module sop_cfg_regs
  import sop_pkg::*;
#(
  parameter int N_MC  = 16,
  parameter int N_PT  = 5,
  parameter int N_SHX = 2,
  parameter int LIT_W = 20,
  parameter int AW    = 7
) (
  input  logic                               clk,
  input  logic                               rst_sync_n,
  input  logic                               cfg_we,
  input  logic [AW-1:0]                      cfg_addr,
  input  logic [LIT_W-1:0]                   cfg_data,
  output logic [N_MC*N_PT-1:0][LIT_W-1:0]    term_mask,
  output logic [N_SHX-1:0][LIT_W-1:0]        shx_mask,
  output logic [N_MC-1:0][CTRL_W-1:0]        ctrl_word
);

  localparam int N_TERM    = N_MC * N_PT;
  localparam int SHX_BASE  = N_TERM;
  localparam int CTRL_BASE = N_TERM + N_SHX;

  for (genvar i = 0; i < N_TERM; i++) begin : g_term
    logic [LIT_W-1:0] nxt;
    always_comb begin
      nxt = term_mask[i];
      if (cfg_we && cfg_addr == AW'(i)) nxt = cfg_data;
    end
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) term_mask[i] <= '0;
      else             term_mask[i] <= nxt;
    end
  end

  for (genvar s = 0; s < N_SHX; s++) begin : g_shx
    logic [LIT_W-1:0] nxt;
    always_comb begin
      nxt = shx_mask[s];
      if (cfg_we && cfg_addr == AW'(SHX_BASE + s)) nxt = cfg_data;
    end
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) shx_mask[s] <= '0;
      else             shx_mask[s] <= nxt;
    end
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_ctrl
    logic [CTRL_W-1:0] nxt;
    always_comb begin
      nxt = ctrl_word[m];
      if (cfg_we && cfg_addr == AW'(CTRL_BASE + m)) nxt = cfg_data[CTRL_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) ctrl_word[m] <= '0;
      else             ctrl_word[m] <= nxt;
    end
  end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_IN   = 8,
  parameter int N_SHX  = 2,
  parameter int N_TERM = 80,
  parameter int LIT_W  = 2 * (N_IN + N_SHX)
) (
  input  logic [N_IN-1:0]                 pin_in,
  input  logic [N_TERM-1:0][LIT_W-1:0]    term_mask,
  input  logic [N_SHX-1:0][LIT_W-1:0]     shx_mask,
  output logic [N_SHX-1:0]                shx_out,
  output logic [N_TERM-1:0]               terms
);

  localparam int PIN_W = 2 * N_IN;
  localparam logic [LIT_W-1:0] PIN_ONLY = {{(LIT_W-PIN_W){1'b0}}, {PIN_W{1'b1}}};

  logic [LIT_W-1:0] lit;

  function automatic logic pterm(input logic [LIT_W-1:0] l, input logic [LIT_W-1:0] mk);
    return (|mk) && ((l & mk) == mk);
  endfunction

  for (genvar p = 0; p < N_IN; p++) begin : g_pin_lit
    assign lit[2*p]   = pin_in[p];
    assign lit[2*p+1] = ~pin_in[p];
  end

  // First pass: expanders see pin literals only.
  for (genvar s = 0; s < N_SHX; s++) begin : g_shx
    assign shx_out[s]          = ~pterm(lit, shx_mask[s] & PIN_ONLY);
    assign lit[PIN_W + 2*s]    = shx_out[s];
    assign lit[PIN_W + 2*s + 1] = ~shx_out[s];
  end

  // Second pass: macrocell terms see pins and expanders.
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assign terms[t] = pterm(lit, term_mask[t]);
  end

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_pkg::*;
#(
  parameter int N_PT = 5
) (
  input  logic            clk,
  input  logic            rst_sync_n,
  input  logic [N_PT-1:0] terms,
  input  logic            exp_in,
  input  mc_ctrl_t        ctrl,
  output logic            d,
  output logic            q,
  output logic            clr_t,
  output logic            pre_t,
  output logic            ena_t,
  output logic            out
);

  logic [N_PT-1:0] sum_mask;
  logic            a_clr;
  logic            a_set;
  logic            q_nxt;

  always_comb begin
    sum_mask         = '1;
    sum_mask[T_CLR]  = ~ctrl.steer_clr;
    sum_mask[T_PRE]  = ~ctrl.steer_pre;
    sum_mask[T_ENA]  = ~ctrl.steer_ena;
    sum_mask[T_LEND] = ~ctrl.lend;
  end

  assign d     = ctrl.inv ^ ((|(terms & sum_mask)) | exp_in);
  assign clr_t = ctrl.steer_clr & terms[T_CLR];
  assign pre_t = ctrl.steer_pre & terms[T_PRE];
  assign ena_t = ctrl.steer_ena ? terms[T_ENA] : 1'b1;

  assign a_clr = ~rst_sync_n | clr_t;
  assign a_set = pre_t & ~a_clr;

  always_comb begin
    q_nxt = q;
    if (ena_t) q_nxt = d;
  end

  always_ff @(posedge clk or posedge a_clr or posedge a_set) begin
    if (a_clr)      q <= 1'b0;
    else if (a_set) q <= 1'b1;
    else            q <= q_nxt;
  end

  assign out = ctrl.bypass ? d : q;

endmodule

// File: rtl/sop_macro_block.sv
module sop_macro_block
  import sop_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_PT  = 5,
  parameter int N_MC  = 16,
  parameter int N_SHX = 2,
  localparam int LIT_W  = 2 * (N_IN + N_SHX),
  localparam int N_TERM = N_MC * N_PT,
  localparam int AW     = $clog2(N_TERM + N_SHX + N_MC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  pin_in,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [LIT_W-1:0] cfg_data,
  output logic [N_MC-1:0]  mc_out
);

  logic                           rst_sync_n;
  logic [N_TERM-1:0][LIT_W-1:0]   term_mask;
  logic [N_SHX-1:0][LIT_W-1:0]    shx_mask;
  logic [N_MC-1:0][CTRL_W-1:0]    ctrl_word;
  logic [N_SHX-1:0]               shx_out;
  logic [N_TERM-1:0]              terms;
  logic [N_MC-1:0]                exp_link;
  logic [N_MC-1:0]                mc_d;
  logic [N_MC-1:0]                mc_q;
  logic [N_MC-1:0]                mc_clr;
  logic [N_MC-1:0]                mc_pre;
  logic [N_MC-1:0]                mc_ena;

  sop_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sop_cfg_regs #(
    .N_MC (N_MC), .N_PT (N_PT), .N_SHX (N_SHX), .LIT_W (LIT_W), .AW (AW)
  ) i_cfg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_data   (cfg_data),
    .term_mask  (term_mask),
    .shx_mask   (shx_mask),
    .ctrl_word  (ctrl_word)
  );

  sop_and_plane #(
    .N_IN (N_IN), .N_SHX (N_SHX), .N_TERM (N_TERM), .LIT_W (LIT_W)
  ) i_plane (
    .pin_in    (pin_in),
    .term_mask (term_mask),
    .shx_mask  (shx_mask),
    .shx_out   (shx_out),
    .terms     (terms)
  );

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    mc_ctrl_t ctrl;
    assign ctrl = mc_ctrl_t'(ctrl_word[m]);

    // Lent term arrives only from the macrocell just below.
    if (m == 0) begin : g_first
      assign exp_link[m] = 1'b0;
    end else begin : g_chain
      assign exp_link[m] = ctrl_word[m-1][5] & terms[(m-1)*N_PT + T_LEND];
    end

    sop_macrocell #(.N_PT (N_PT)) i_mc (
      .clk        (clk),
      .rst_sync_n (rst_sync_n),
      .terms      (terms[m*N_PT +: N_PT]),
      .exp_in     (exp_link[m]),
      .ctrl       (ctrl),
      .d          (mc_d[m]),
      .q          (mc_q[m]),
      .clr_t      (mc_clr[m]),
      .pre_t      (mc_pre[m]),
      .ena_t      (mc_ena[m]),
      .out        (mc_out[m])
    );
  end

endmodule

// File: rtl/sop_macro_block_chk.sv
module sop_macro_block_chk #(
  parameter int N_MC = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rst_sync_n,
  input logic [N_MC-1:0] mc_d,
  input logic [N_MC-1:0] mc_q,
  input logic [N_MC-1:0] mc_clr,
  input logic [N_MC-1:0] mc_pre,
  input logic [N_MC-1:0] mc_ena
);

  assert_reset_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> (mc_q == '0));

  for (genvar m = 0; m < N_MC; m++) begin : g_m
    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      mc_clr[m] |-> !mc_q[m]);

    assert_preset_sets_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (mc_pre[m] && !mc_clr[m]) |-> mc_q[m]);

    assert_enable_holds_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!mc_ena[m] && !mc_clr[m] && !mc_pre[m]) |=>
        (mc_clr[m] || mc_pre[m] || mc_q[m] == $past(mc_q[m])));

    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (mc_ena[m] && !mc_clr[m] && !mc_pre[m]) |=>
        (mc_clr[m] || mc_pre[m] || mc_q[m] == $past(mc_d[m])));
  end

endmodule

bind sop_macro_block sop_macro_block_chk #(.N_MC (N_MC)) i_chk (.*);

// File: tb/test_sop_macro_block.sv
module test_sop_macro_block;

  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 8, N_PT = 5, N_MC = 16, N_SHX = 2;
  localparam int LIT_W = 2 * (N_IN + N_SHX);
  localparam int SHX_BASE = N_MC * N_PT;
  localparam int CTRL_BASE = SHX_BASE + N_SHX;
  localparam int INV = 1, BYP = 2, SCLR = 4, SPRE = 8, SENA = 16, LEND = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [N_IN-1:0] pin_in;
  logic cfg_we;
  logic [6:0] cfg_addr;
  logic [LIT_W-1:0] cfg_data;
  logic [N_MC-1:0] mc_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state for random configurations
  logic [LIT_W-1:0] m_term [N_MC][N_PT];
  logic [LIT_W-1:0] m_shx [N_SHX];
  int m_ctrl [N_MC];

  sop_macro_block i_sop_macro_block (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .mc_out(mc_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [LIT_W-1:0] lt(input int s);
    return LIT_W'(1) << (2*s);
  endfunction
  function automatic logic [LIT_W-1:0] lc(input int s);
    return LIT_W'(1) << (2*s + 1);
  endfunction

  task automatic wr(input int addr, input logic [LIT_W-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = addr[6:0]; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask
  task automatic wr_term(input int m, input int t, input logic [LIT_W-1:0] mk);
    wr(m*N_PT + t, mk);
  endtask
  task automatic wr_ctrl(input int m, input int c);
    wr(CTRL_BASE + m, LIT_W'(c));
  endtask

  task automatic set_pins(input logic [N_IN-1:0] v);
    @(negedge clk);
    pin_in = v;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pin_in = '0; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // R11: reset clears registers and configuration
  task automatic t_reset_state();
    do_reset();
    chk("R11 outputs after reset", 32'(mc_out), 32'h0);
    wr_term(0, 0, lt(0));
    wr_ctrl(0, BYP);
    set_pins(8'h01);
    chk("R11 pre-reset config active", 32'(mc_out[0]), 32'h1);
    do_reset();
    chk("R11 outputs zero after second reset", 32'(mc_out), 32'h0);
    pin_in = 8'h01;
    wr_ctrl(0, BYP | INV);
    #1;
    chk("R11 term config cleared by reset", 32'(mc_out[0]), 32'h1);
  endtask

  // R1 R2 R3: literals, sum in bypass, inversion
  task automatic t_literals();
    do_reset();
    wr_term(0, 0, lt(0) | lc(1));
    wr_ctrl(0, BYP);
    wr_ctrl(1, BYP);
    wr_ctrl(2, INV);
    for (int v = 0; v < 4; v++) begin
      set_pins(8'(v));
      chk("R1 R2 in0 and not in1", 32'(mc_out[0]), 32'((v == 1) ? 1 : 0));
      chk("R1 empty mask is off", 32'(mc_out[1]), 32'h0);
    end
    chk("R3 inversion ahead of register", 32'(mc_out[2]), 32'h1);
    wr_ctrl(0, BYP | INV);
    set_pins(8'h01);
    chk("R3 inverted sum true", 32'(mc_out[0]), 32'h0);
    set_pins(8'h00);
    chk("R3 inverted sum false", 32'(mc_out[0]), 32'h1);
  endtask

  // R4: registered capture at rising edge
  task automatic t_register();
    do_reset();
    wr_term(1, 0, lt(2));
    wr_ctrl(1, 0);
    set_pins(8'h04);
    chk("R4 no change before edge", 32'(mc_out[1]), 32'h0);
    @(negedge clk);
    chk("R4 captured one", 32'(mc_out[1]), 32'h1);
    set_pins(8'h00);
    chk("R4 holds before edge", 32'(mc_out[1]), 32'h1);
    @(negedge clk);
    chk("R4 captured zero", 32'(mc_out[1]), 32'h0);
  endtask

  // R5: term 3 as capture enable
  task automatic t_enable();
    do_reset();
    wr_term(1, 0, lt(2));
    wr_term(1, 3, lt(3));
    wr_ctrl(1, SENA);
    set_pins(8'h04);
    @(negedge clk);
    chk("R5 hold while enable low", 32'(mc_out[1]), 32'h0);
    set_pins(8'h0C);
    @(negedge clk);
    chk("R5 capture while enable high", 32'(mc_out[1]), 32'h1);
    set_pins(8'h08);
    @(negedge clk);
    chk("R5 enable term not in sum", 32'(mc_out[1]), 32'h0);
  endtask

  // R6 R7: asynchronous clear and preset
  task automatic t_async();
    do_reset();
    wr_term(2, 0, lt(4));
    wr_term(2, 1, lt(5));
    wr_term(2, 2, lt(6));
    wr_ctrl(2, SCLR | SPRE);
    set_pins(8'h10);
    @(negedge clk);
    chk("R6 setup load one", 32'(mc_out[2]), 32'h1);
    set_pins(8'h30);
    chk("R6 async clear without edge", 32'(mc_out[2]), 32'h0);
    set_pins(8'h40);
    chk("R7 async preset without edge", 32'(mc_out[2]), 32'h1);
    set_pins(8'h60);
    chk("R6 clear wins over preset", 32'(mc_out[2]), 32'h0);
  endtask

  // R8: parallel expander to adjacent macrocell only
  task automatic t_parallel();
    do_reset();
    wr_term(3, 4, lt(7));
    wr_ctrl(3, BYP | LEND);
    wr_ctrl(4, BYP);
    wr_ctrl(5, BYP);
    wr_term(15, 4, lt(7));
    wr_ctrl(15, BYP | LEND);
    wr_ctrl(0, BYP);
    set_pins(8'h80);
    chk("R8 lent term only in next macrocell", 32'(mc_out), 32'h0010);
    set_pins(8'h00);
    chk("R8 lent term false", 32'(mc_out), 32'h0000);
  endtask

  // R9: shared expanders
  task automatic t_shared();
    do_reset();
    wr(SHX_BASE + 0, lt(0) | lt(1) | lc(9));
    wr_term(0, 0, lt(8));
    wr_term(1, 0, lc(8));
    wr_ctrl(0, BYP);
    wr_ctrl(1, BYP);
    for (int v = 0; v < 4; v++) begin
      set_pins(8'(v));
      chk("R9 expander is NAND of pins", 32'(mc_out[1:0]), 32'((v == 3) ? 2 : 1));
    end
  endtask

  // R10: write timing and address range
  task automatic t_cfg();
    do_reset();
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(CTRL_BASE); cfg_data = LIT_W'(BYP | INV);
    #1;
    chk("R10 no effect before edge", 32'(mc_out[0]), 32'h0);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R10 effect after edge", 32'(mc_out[0]), 32'h1);
    wr(127, '1);
    wr(98, '1);
    set_pins(8'hFF);
    chk("R10 out of range write ignored", 32'(mc_out), 32'h0001);
  endtask

  function automatic logic pt(input logic [LIT_W-1:0] l, input logic [LIT_W-1:0] mk);
    return (mk != 0) && ((l & mk) == mk);
  endfunction

  function automatic logic [N_MC-1:0] model(input logic [N_IN-1:0] p);
    logic [LIT_W-1:0] l;
    logic [LIT_W-1:0] pmask;
    logic [N_MC-1:0] r;
    logic s;
    l = '0;
    pmask = '0;
    for (int i = 0; i < N_IN; i++) begin
      l[2*i] = p[i]; l[2*i+1] = ~p[i];
      pmask[2*i] = 1'b1; pmask[2*i+1] = 1'b1;
    end
    for (int x = 0; x < N_SHX; x++) begin
      s = ~pt(l, m_shx[x] & pmask);
      l[2*(N_IN+x)] = s; l[2*(N_IN+x)+1] = ~s;
    end
    for (int m = 0; m < N_MC; m++) begin
      s = 1'b0;
      for (int t = 0; t < 4; t++) s |= pt(l, m_term[m][t]);
      if ((m_ctrl[m] & LEND) == 0) s |= pt(l, m_term[m][4]);
      if (m > 0 && (m_ctrl[m-1] & LEND) != 0) s |= pt(l, m_term[m-1][4]);
      r[m] = s ^ ((m_ctrl[m] & INV) != 0);
    end
    return r;
  endfunction

  function automatic logic [LIT_W-1:0] rmask(input int nsig);
    logic [LIT_W-1:0] mk = '0;
    int k = $urandom_range(0, 2);
    for (int i = 0; i < k; i++) mk |= LIT_W'(1) << $urandom_range(0, 2*nsig - 1);
    return mk;
  endfunction

  // R2 R3 R8 R9: random configurations against the sum-of-products model
  task automatic t_random();
    for (int round = 0; round < 3; round++) begin
      do_reset();
      for (int x = 0; x < N_SHX; x++) begin
        m_shx[x] = rmask(N_IN);
        wr(SHX_BASE + x, m_shx[x]);
      end
      for (int m = 0; m < N_MC; m++) begin
        for (int t = 0; t < N_PT; t++) begin
          m_term[m][t] = rmask(N_IN + N_SHX);
          wr_term(m, t, m_term[m][t]);
        end
        m_ctrl[m] = BYP | ($urandom_range(0, 1) * INV) | ($urandom_range(0, 1) * LEND);
        wr_ctrl(m, m_ctrl[m]);
      end
      for (int v = 0; v < 12; v++) begin
        logic [N_IN-1:0] p = 8'($urandom);
        set_pins(p);
        chk("R2 R3 R8 R9 random model", 32'(mc_out), 32'(model(p)));
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    pin_in = '0;
    cfg_we = 1'b0;
    cfg_addr = '0;
    cfg_data = '0;
    t_reset_state();
    t_literals();
    t_register();
    t_enable();
    t_async();
    t_parallel();
    t_shared();
    t_cfg();
    t_random();
    finish_run();
  end

endmodule